// File: doc/BRIEF.md
# Bidirectional Signed-Count Shifter

This block is a purely combinational 8-bit shifter. It takes a data word, a two-bit operation select and a four-bit signed shift count, and it returns the shifted word in the same cycle. The sign of the count picks the direction, so no separate left/right control is needed. A negative count moves bits toward the MSB and a positive count moves them toward the LSB. The magnitude of the count gives the number of bit positions.

Three operations are provided. Logical shifts bring in zeros. Arithmetic shifts bring in copies of the sign bit when moving right and zeros when moving left. Rotates wrap the bits that leave one end back in at the other end. The fourth select value is held back for later use and returns the data unchanged.

The shifter can sit in an ALU datapath next to the adder and logic unit. It needs no clock, and its output settles once its inputs are stable.

Top module: `bsh_signed_shifter`

## Requirements
- R1: `dout` is an 8-bit combinational function of `din`, `mode` and `cnt`, and it is valid in the same cycle the inputs are applied.
- R2: `cnt` is 4-bit two's complement. A value from -7 to -1 moves bits left (toward bit 7) by its magnitude. A value from +1 to +7 moves bits right (toward bit 0) by its value.
- R3: With `mode` = 2'b00 (logical), the vacated bit positions are filled with zeros. For example, 11001010 with count +2 gives 00110010.
- R4: With `mode` = 2'b01 (arithmetic) and a positive count, the vacated high bits are filled with copies of `din[7]`. For example, 11001010 with count +3 gives 11111001.
- R5: For a negative count, the arithmetic mode fills the vacated low bits with zeros. Its result is identical to the logical mode for the same data and count.
- R6: With `mode` = 2'b10 (rotate), the bits shifted out at one end come back in at the other end. For example, 11001010 with count -2 gives 00101011, and with count -1 gives 10010101.
- R7: A count of 0 and a count of 4'b1000 (-8) both pass `din` to `dout` unchanged, in every mode.
- R8: With `mode` = 2'b11 (reserved), `dout` equals `din` for every count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Data word to be shifted |
| mode | input | 2 | Operation: 00 logical, 01 arithmetic, 10 rotate, 11 reserved (pass-through) |
| cnt | input | 4 | Signed two's-complement count; negative moves left, positive moves right |
| dout | output | 8 | Shifted result |

## Verification
The bound checker tests, on every input change, the properties that hold for any data word:
- zero fill at the vacated end for logical shifts and for left shifts;
- sign fill at the high end for arithmetic right shifts;
- preservation of the number of set bits under rotation;
- pass-through for the reserved mode and for counts 0 and -8.

Only the bench scenarios can show that each bit lands in its exact position and that the direction follows the sign of the count. The bench compares against a bit-by-bit model and runs an exhaustive sweep of every mode and count over a set of data words. The same sweep is the only way to show that the arithmetic and logical modes agree for left shifts.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  localparam int DATA_W = 8;
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int CNT_W  = AMT_W + 1;

  typedef enum logic [1:0] {
    OP_LOGIC = 2'b00,
    OP_ARITH = 2'b01,
    OP_ROT   = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_SIGN = 2'b01,
    FILL_WRAP = 2'b10
  } fill_e;

  // Magnitude of a signed count, folded into AMT_W bits (so -8 folds to 0).
  function automatic logic [AMT_W-1:0] count_mag(input logic [CNT_W-1:0] c);
    logic [AMT_W-1:0] low;
    low = c[AMT_W-1:0];
    if (c[CNT_W-1]) count_mag = ~low + {{(AMT_W-1){1'b0}}, 1'b1};
    else            count_mag = low;
  endfunction

  // Mask of the top n bits of a data word.
  function automatic logic [DATA_W-1:0] high_mask(input logic [AMT_W-1:0] n);
    high_mask = ~({DATA_W{1'b1}} >> n);
  endfunction

  // Mask of the bottom n bits of a data word.
  function automatic logic [DATA_W-1:0] low_mask(input logic [AMT_W-1:0] n);
    low_mask = ~({DATA_W{1'b1}} << n);
  endfunction

endpackage

// File: rtl/bsh_count_dec.sv
module bsh_count_dec
  import bsh_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int AW = AMT_W
) (
  input  logic [CW-1:0] cnt,
  output logic          go_left,
  output logic [AW-1:0] amt
);
  logic [AW-1:0] low;

  assign low     = cnt[AW-1:0];
  assign go_left = cnt[CW-1];
  assign amt     = go_left ? (~low + {{(AW-1){1'b0}}, 1'b1}) : low;
endmodule

// File: rtl/bsh_reverse.sv
module bsh_reverse #(
  parameter int W = bsh_pkg::DATA_W
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = a[W-1-i];
  end
endmodule

// File: rtl/bsh_right_core.sv
module bsh_right_core
  import bsh_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int AW = AMT_W
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  input  fill_e         fill,
  output logic [W-1:0]  y
);
  logic [W-1:0] st [0:AW];
  logic         wrap;
  logic         use_sign;

  assign wrap     = (fill == FILL_WRAP);
  assign use_sign = (fill == FILL_SIGN);
  assign st[0]    = a;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [SH-1:0] fillv;
    assign fillv    = wrap ? st[s][SH-1:0] : {SH{use_sign & st[s][W-1]}};
    assign st[s+1]  = amt[s] ? {fillv, st[s][W-1:SH]} : st[s];
  end

  assign y = st[AW];
endmodule

// File: rtl/bsh_signed_shifter.sv
module bsh_signed_shifter
  import bsh_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int AW    = $clog2(WIDTH),
  parameter int CW    = AW + 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       mode,
  input  logic [CW-1:0]    cnt,
  output logic [WIDTH-1:0] dout
);
  logic             go_left;
  logic [AW-1:0]    amt;
  logic             reserved;
  fill_e            fill;
  logic [WIDTH-1:0] rev_in;
  logic [WIDTH-1:0] core_in;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] rev_out;

  bsh_count_dec #(.CW(CW), .AW(AW)) u_dec (
    .cnt     (cnt),
    .go_left (go_left),
    .amt     (amt)
  );

  assign reserved = (mode == OP_RSVD);

  always_comb begin
    if (mode == OP_ROT)                    fill = FILL_WRAP;
    else if (mode == OP_ARITH && !go_left) fill = FILL_SIGN;
    else                                   fill = FILL_ZERO;
  end

  bsh_reverse #(.W(WIDTH)) u_rev_in  (.a(din),      .y(rev_in));
  assign core_in = go_left ? rev_in : din;

  bsh_right_core #(.W(WIDTH), .AW(AW)) u_core (
    .a    (core_in),
    .amt  (amt),
    .fill (fill),
    .y    (core_out)
  );

  bsh_reverse #(.W(WIDTH)) u_rev_out (.a(core_out), .y(rev_out));

  assign dout = reserved ? din : (go_left ? rev_out : core_out);
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker
  import bsh_pkg::*;
(
  input logic [DATA_W-1:0] din,
  input logic [1:0]        mode,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] dout,
  input logic              go_left,
  input logic [AMT_W-1:0]  amt
);
  logic [DATA_W-1:0] hm;
  logic [DATA_W-1:0] lm;

  always_comb begin
    hm = high_mask(amt);
    lm = low_mask(amt);
    if (!$isunknown({din, mode, cnt, dout})) begin
      a_r8_reserved_pass: assert (mode != 2'b11 || dout == din)
        else $error("R8 reserved mode altered data");
      a_r7_zero_count_pass: assert (!(cnt == 4'b0000 || cnt == 4'b1000) || dout == din)
        else $error("R7 zero/-8 count altered data");
      a_r6_rotate_keeps_ones: assert (mode != 2'b10 || $countones(dout) == $countones(din))
        else $error("R6 rotate changed set-bit count");
      a_r3_logic_right_zero: assert (!(mode == 2'b00 && !go_left) || (dout & hm) == '0)
        else $error("R3 logical right fill not zero");
      a_r4_arith_sign_fill: assert (!(mode == 2'b01 && !go_left) ||
                                    (dout & hm) == (din[DATA_W-1] ? hm : '0))
        else $error("R4 arithmetic fill not sign");
      a_r5_left_zero_fill: assert (!((mode == 2'b00 || mode == 2'b01) && go_left) ||
                                   (dout & lm) == '0)
        else $error("R5 left fill not zero");
    end
  end
endmodule

bind bsh_signed_shifter bsh_checker u_chk (
  .din     (din),
  .mode    (mode),
  .cnt     (cnt),
  .dout    (dout),
  .go_left (go_left),
  .amt     (amt)
);

// File: tb/tb_bsh_signed_shifter.sv
`timescale 1ns/1ps
module tb_bsh_signed_shifter;
  logic       clk = 1'b0;
  logic [7:0] din;
  logic [1:0] mode;
  logic [3:0] cnt;
  logic [7:0] dout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bsh_signed_shifter dut (.din(din), .mode(mode), .cnt(cnt), .dout(dout));

  function automatic logic [7:0] model(logic [7:0] d, logic [1:0] m, logic [3:0] c);
    int n, k;
    logic [7:0] r;
    n = (c >= 8) ? int'(c) - 16 : int'(c);
    if (m == 2'b11 || n == 0 || n == -8) return d;
    k = (n < 0) ? -n : n;
    for (int i = 0; i < 8; i++) begin
      int src;
      src = (n > 0) ? i + k : i - k;
      if (m == 2'b10)              r[i] = d[(src + 8) % 8];
      else if (src >= 0 && src < 8) r[i] = d[src];
      else if (m == 2'b01 && n > 0) r[i] = d[7];
      else                          r[i] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s din=%b mode=%b cnt=%0d got=%b exp=%b", req, din, mode, cnt, got, exp);
    end
  endtask

  task automatic apply(logic [7:0] d, logic [1:0] m, logic [3:0] c);
    @(negedge clk);
    din = d; mode = m; cnt = c;
    #1;
  endtask

  task automatic t_idle;
    apply(8'h00, 2'b00, 4'd0);
    check("R1 idle", dout, 8'h00);
  endtask

  task automatic t_examples;
    apply(8'hCA, 2'b10, 4'b1110); check("R6 rot -2", dout, 8'h2B);
    apply(8'hCA, 2'b10, 4'b1111); check("R6 rot -1", dout, 8'h95);
    apply(8'hCA, 2'b01, 4'd3);    check("R4 arith +3", dout, 8'hF9);
    apply(8'hCA, 2'b00, 4'd2);    check("R3 logic +2", dout, 8'h32);
  endtask

  task automatic t_direction;
    apply(8'h01, 2'b00, 4'b1101); check("R2 left by 3", dout, 8'h08);
    apply(8'h80, 2'b00, 4'd7);    check("R2 right by 7", dout, 8'h01);
    apply(8'h80, 2'b10, 4'd1);    check("R6 rot +1", dout, 8'h40);
    apply(8'h01, 2'b10, 4'd1);    check("R6 rot wrap", dout, 8'h80);
  endtask

  task automatic t_arith_left;
    apply(8'hB5, 2'b01, 4'b1110); check("R5 arith -2", dout, 8'hD4);
    apply(8'hB5, 2'b00, 4'b1110); check("R5 logic -2", dout, 8'hD4);
    apply(8'h4A, 2'b01, 4'd2);    check("R4 positive sign", dout, 8'h12);
  endtask

  task automatic t_passthru;
    for (int m = 0; m < 4; m++) begin
      apply(8'h5C, m[1:0], 4'd0);    check("R7 count 0", dout, 8'h5C);
      apply(8'h5C, m[1:0], 4'b1000); check("R7 count -8", dout, 8'h5C);
    end
    for (int c = 0; c < 16; c++) begin
      apply(8'hA7, 2'b11, c[3:0]); check("R8 reserved", dout, 8'hA7);
    end
  endtask

  task automatic t_sweep;
    logic [7:0] pats [6] = '{8'hCA, 8'h81, 8'h7E, 8'hFF, 8'h35, 8'h00};
    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 4; m++)
        for (int c = 0; c < 16; c++) begin
          apply(pats[p], m[1:0], c[3:0]);
          check("R1 R2 R3 R4 R5 R6 sweep", dout, model(pats[p], m[1:0], c[3:0]));
        end
  endtask

  initial begin
    din = '0; mode = '0; cnt = '0;
    t_idle();
    t_examples();
    t_direction();
    t_arith_left();
    t_passthru();
    t_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule